// File: doc/BRIEF.md
# Four-Channel Co-Processor Register Front End

This block is the software-visible register file of a multi-channel co-processor. It keeps the global settings (a write-gathering switch, a context-caching switch and one interrupt enable per channel), an eight-bit channel-enable mask, a fixed capability word and a context-buffer pointer. It also gives each channel its own 64-byte register window. That window holds a command pointer, a semaphore strobe and a sticky status register. The channel sequencers read the command pointers and the status, and they receive the semaphore strobes. The sequencers report back through done pulses and status-set vectors.

Every done pulse lands in a global pending register. Software clears that register by writing ones to a separate clear address. The single interrupt line is high while any pending bit has its enable bit set. The bus is a plain 32-bit word interface. A read returns its data on the clock edge after the request.

Top module: `copro_regfile`

## Requirements
- R1: After reset, every stored register, `irq`, all strobes and `bus_rdata` are zero.
- R2: The control word at 0x00 keeps only bit 23 (drives `gather_en`), bit 22 (drives `ctx_cache_en`) and bits [NCH-1:0] (per-channel interrupt enables). It reads back those bits and zeros elsewhere, so writing all ones reads 0x00C0000F.
- R3: A `ch_done[n]` pulse sets pending bit n of the word read at 0x10. Writes to 0x10 change nothing.
- R4: A write to 0x18 clears each pending bit whose data bit is one. When a done pulse and a clear hit the same bit in one cycle, the bit ends up set.
- R5: `irq` is high exactly when some pending bit and its matching control enable bit are both one.
- R6: The channel-enable word at 0x20 keeps data bits [7:0] and drives `chan_en`. It reads back zeros above bit 7.
- R7: The word at 0x40 always reads the capability parameter (default 0x00050001: bit 0 AES-128, bit 16 SHA-1, bit 18 SHA-256). Writes to it are ignored.
- R8: The word at 0x50 is a full 32-bit read/write context pointer that drives `ctx_ptr`.
- R9: Channel n's command pointer sits at 0x100 + n*0x40. It is a 32-bit read/write register that drives slice n of `ch_cmd_ptr`.
- R10: A write to 0x110 + n*0x40 makes `ch_sema_wr[n]` high for exactly the one cycle after the write, with the written word on `ch_sema_data`. Reads of that address return zero.
- R11: Channel n's status at 0x120 + n*0x40 gathers the bits of `ch_stat_set` slice n (sticky OR, 8 bits). A write to 0x128 + n*0x40 clears the bits that are one in data [7:0], so writing all ones wipes the register. A set beats a clear of the same bit in the same cycle.
- R12: A read of any unmapped or non-word-aligned address returns zero. A write to such an address changes no register and no output.
- R13: `bus_rdata` changes only on the clock edge that samples `bus_rd`. It holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read request this cycle |
| bus_wr | input | 1 | Write request this cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Combined interrupt |
| gather_en | output | 1 | Residual-write gathering switch |
| ctx_cache_en | output | 1 | Context-caching switch |
| chan_en | output | 8 | Channel-enable mask |
| ctx_ptr | output | 32 | Context-buffer pointer |
| ch_done | input | NCH | Per-channel completion pulses |
| ch_cmd_ptr | output | NCH*32 | Command pointers, channel n at [32n+31:32n] |
| ch_sema_wr | output | NCH | Per-channel semaphore write strobes |
| ch_sema_data | output | 32 | Word from the latest semaphore write |
| ch_stat_set | input | NCH*8 | Per-channel status bits to set |
| ch_stat | output | NCH*8 | Per-channel status registers |

## Verification
The assertions rely on a few properties of the inputs. Completion pulses and status-set vectors may arrive in any cycle, including the cycle of a clear. The bus may issue at most one read and one write per cycle. The checks on pending and status bits count on software clearing only through the clear aliases.

The stimulus drives every input half a cycle away from the sampling edge and issues one access per cycle. It deliberately puts a set and a clear of the same bit into one cycle, so the set-wins ordering is exercised.

// File: rtl/copro_reg_pkg.sv
package copro_reg_pkg;

    // Global register word offsets
    localparam int OFF_CTRL     = 'h00;
    localparam int OFF_STAT     = 'h10;
    localparam int OFF_STAT_CLR = 'h18;
    localparam int OFF_CHEN     = 'h20;
    localparam int OFF_CAP      = 'h40;
    localparam int OFF_CTX      = 'h50;

    // Per-channel windows
    localparam int CH_BASE   = 'h100;
    localparam int CH_SHIFT  = 6;
    localparam int CH_STRIDE = 1 << CH_SHIFT;

    // Offsets inside a channel window
    localparam logic [5:0] WIN_CMD      = 6'h00;
    localparam logic [5:0] WIN_SEMA     = 6'h10;
    localparam logic [5:0] WIN_STAT     = 6'h20;
    localparam logic [5:0] WIN_STAT_CLR = 6'h28;

    // Control word field positions
    localparam int BIT_GATHER = 23;
    localparam int BIT_CACHE  = 22;

    localparam int CHEN_W = 8;

    typedef enum logic [3:0] {
        ACC_NONE,
        ACC_CTRL,
        ACC_STAT,
        ACC_STAT_CLR,
        ACC_CHEN,
        ACC_CAP,
        ACC_CTX,
        ACC_CMD,
        ACC_SEMA,
        ACC_CSTAT,
        ACC_CSTAT_CLR
    } acc_kind_e;

    // Index width for a channel count of at least one
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/copro_addr_dec.sv
module copro_addr_dec
    import copro_reg_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 12,
    localparam int CH_IDX_W = idx_width(NCH)
) (
    input  logic [ADDR_W-1:0]   addr,
    output acc_kind_e           kind,
    output logic [CH_IDX_W-1:0] chan
);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_SCLR   = ADDR_W'(OFF_STAT_CLR);
    localparam logic [ADDR_W-1:0] A_CHEN   = ADDR_W'(OFF_CHEN);
    localparam logic [ADDR_W-1:0] A_CAP    = ADDR_W'(OFF_CAP);
    localparam logic [ADDR_W-1:0] A_CTX    = ADDR_W'(OFF_CTX);
    localparam logic [ADDR_W-1:0] A_CHBEG  = ADDR_W'(CH_BASE);
    localparam logic [ADDR_W-1:0] A_CHEND  = ADDR_W'(CH_BASE + NCH * CH_STRIDE);

    logic [ADDR_W-1:0] rel;
    logic [5:0]        win_off;

    assign rel     = addr - A_CHBEG;
    assign win_off = addr[5:0];

    always_comb begin
        kind = ACC_NONE;
        chan = CH_IDX_W'(rel >> CH_SHIFT);
        if (addr == A_CTRL)      kind = ACC_CTRL;
        else if (addr == A_STAT) kind = ACC_STAT;
        else if (addr == A_SCLR) kind = ACC_STAT_CLR;
        else if (addr == A_CHEN) kind = ACC_CHEN;
        else if (addr == A_CAP)  kind = ACC_CAP;
        else if (addr == A_CTX)  kind = ACC_CTX;
        else if (addr >= A_CHBEG && addr < A_CHEND) begin
            case (win_off)
                WIN_CMD:      kind = ACC_CMD;
                WIN_SEMA:     kind = ACC_SEMA;
                WIN_STAT:     kind = ACC_CSTAT;
                WIN_STAT_CLR: kind = ACC_CSTAT_CLR;
                default:      kind = ACC_NONE;
            endcase
        end
    end
endmodule

// File: rtl/copro_glob_regs.sv
module copro_glob_regs
    import copro_reg_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_stat_clr,
    input  logic              wr_chen,
    input  logic              wr_ctx,
    input  logic [31:0]       wdata,
    input  logic [NCH-1:0]    ch_done,
    output logic [31:0]       ctrl_word,
    output logic [NCH-1:0]    pend,
    output logic [CHEN_W-1:0] chen,
    output logic [31:0]       ctx,
    output logic              gather,
    output logic              cache,
    output logic              irq
);
    logic [NCH-1:0] ien_q;
    logic [NCH-1:0] pend_q;
    logic           gather_q, cache_q;
    logic [CHEN_W-1:0] chen_q;
    logic [31:0]    ctx_q;
    logic [NCH-1:0] clr_mask;

    assign clr_mask = wr_stat_clr ? wdata[NCH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q    <= '0;
            gather_q <= 1'b0;
            cache_q  <= 1'b0;
            chen_q   <= '0;
            ctx_q    <= '0;
            pend_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                ien_q    <= wdata[NCH-1:0];
                gather_q <= wdata[BIT_GATHER];
                cache_q  <= wdata[BIT_CACHE];
            end
            if (wr_chen) chen_q <= wdata[CHEN_W-1:0];
            if (wr_ctx)  ctx_q  <= wdata;
            // set has priority over clear
            pend_q <= (pend_q & ~clr_mask) | ch_done;
        end
    end

    always_comb begin
        ctrl_word             = '0;
        ctrl_word[NCH-1:0]    = ien_q;
        ctrl_word[BIT_GATHER] = gather_q;
        ctrl_word[BIT_CACHE]  = cache_q;
    end

    assign pend   = pend_q;
    assign chen   = chen_q;
    assign ctx    = ctx_q;
    assign gather = gather_q;
    assign cache  = cache_q;
    assign irq    = |(pend_q & ien_q);

    p_done_sets_r3: assert property (@(posedge clk) disable iff (rst)
        (ch_done != '0) |=> ((pend_q & $past(ch_done)) == $past(ch_done)));

    p_pend_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (ch_done == '0 && !wr_stat_clr) |=> $stable(pend_q));

    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_stat_clr && ch_done == '0) |=> ((pend_q & $past(wdata[NCH-1:0])) == '0));
endmodule

// File: rtl/copro_chan_win.sv
module copro_chan_win #(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_cmd,
    input  logic              wr_sema,
    input  logic              wr_clr,
    input  logic [31:0]       wdata,
    input  logic [STAT_W-1:0] stat_set,
    output logic [31:0]       cmd_ptr,
    output logic              sema_wr,
    output logic [STAT_W-1:0] stat
);
    logic [31:0]       cmd_q;
    logic              sema_q;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] clr_mask;

    assign clr_mask = wr_clr ? wdata[STAT_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            sema_q <= 1'b0;
            stat_q <= '0;
        end else begin
            if (wr_cmd) cmd_q <= wdata;
            sema_q <= wr_sema;
            stat_q <= (stat_q & ~clr_mask) | stat_set;
        end
    end

    assign cmd_ptr = cmd_q;
    assign sema_wr = sema_q;
    assign stat    = stat_q;

    p_cmd_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_cmd |=> $stable(cmd_q));

    p_stat_set_r11: assert property (@(posedge clk) disable iff (rst)
        (stat_set != '0) |=> ((stat_q & $past(stat_set)) == $past(stat_set)));

    p_stat_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (stat_set == '0 && !wr_clr) |=> $stable(stat_q));
endmodule

// File: rtl/copro_regfile.sv
module copro_regfile
    import copro_reg_pkg::*;
#(
    parameter int          NCH      = 4,
    parameter int          ADDR_W   = 12,
    parameter int          STAT_W   = 8,
    parameter logic [31:0] CAP_WORD = 32'h0005_0001
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  irq,
    output logic                  gather_en,
    output logic                  ctx_cache_en,
    output logic [7:0]            chan_en,
    output logic [31:0]           ctx_ptr,
    input  logic [NCH-1:0]        ch_done,
    output logic [NCH*32-1:0]     ch_cmd_ptr,
    output logic [NCH-1:0]        ch_sema_wr,
    output logic [31:0]           ch_sema_data,
    input  logic [NCH*STAT_W-1:0] ch_stat_set,
    output logic [NCH*STAT_W-1:0] ch_stat
);
    localparam int CH_IDX_W = idx_width(NCH);

    acc_kind_e           kind;
    logic [CH_IDX_W-1:0] chan;
    logic [31:0]         ctrl_word;
    logic [NCH-1:0]      pend;
    logic [31:0]         cmd_arr [NCH];
    logic [STAT_W-1:0]   stat_arr [NCH];
    logic [31:0]         rd_mux;
    logic [31:0]         rdata_q;
    logic [31:0]         sema_data_q;

    copro_addr_dec #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .kind (kind),
        .chan (chan)
    );

    copro_glob_regs #(.NCH(NCH)) u_glob (
        .clk         (clk),
        .rst         (rst),
        .wr_ctrl     (bus_wr && kind == ACC_CTRL),
        .wr_stat_clr (bus_wr && kind == ACC_STAT_CLR),
        .wr_chen     (bus_wr && kind == ACC_CHEN),
        .wr_ctx      (bus_wr && kind == ACC_CTX),
        .wdata       (bus_wdata),
        .ch_done     (ch_done),
        .ctrl_word   (ctrl_word),
        .pend        (pend),
        .chen        (chan_en),
        .ctx         (ctx_ptr),
        .gather      (gather_en),
        .cache       (ctx_cache_en),
        .irq         (irq)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic sel;
        assign sel = bus_wr && (chan == CH_IDX_W'(i));
        copro_chan_win #(.STAT_W(STAT_W)) u_win (
            .clk      (clk),
            .rst      (rst),
            .wr_cmd   (sel && kind == ACC_CMD),
            .wr_sema  (sel && kind == ACC_SEMA),
            .wr_clr   (sel && kind == ACC_CSTAT_CLR),
            .wdata    (bus_wdata),
            .stat_set (ch_stat_set[i*STAT_W +: STAT_W]),
            .cmd_ptr  (cmd_arr[i]),
            .sema_wr  (ch_sema_wr[i]),
            .stat     (stat_arr[i])
        );
        assign ch_cmd_ptr[i*32 +: 32]     = cmd_arr[i];
        assign ch_stat[i*STAT_W +: STAT_W] = stat_arr[i];
    end

    always_comb begin
        rd_mux = '0;
        case (kind)
            ACC_CTRL:  rd_mux = ctrl_word;
            ACC_STAT:  rd_mux[NCH-1:0] = pend;
            ACC_CHEN:  rd_mux[7:0] = chan_en;
            ACC_CAP:   rd_mux = CAP_WORD;
            ACC_CTX:   rd_mux = ctx_ptr;
            ACC_CMD:   rd_mux = cmd_arr[chan];
            ACC_CSTAT: rd_mux[STAT_W-1:0] = stat_arr[chan];
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q     <= '0;
            sema_data_q <= '0;
        end else begin
            if (bus_rd) rdata_q <= rd_mux;
            if (bus_wr && kind == ACC_SEMA) sema_data_q <= bus_wdata;
        end
    end

    assign bus_rdata    = rdata_q;
    assign ch_sema_data = sema_data_q;

    p_unmapped_rd_r12: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && kind == ACC_NONE) |=> (bus_rdata == '0));

    p_cap_rd_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && kind == ACC_CAP) |=> (bus_rdata == CAP_WORD));

    p_irq_src_r5: assert property (@(posedge clk) disable iff (rst)
        irq |-> (pend != '0));

    p_sema_single_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_sema_wr));

    p_rd_hold_r13: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/sim_copro_regfile.sv
module sim_copro_regfile;
    localparam int NCH = 4;
    localparam int AW  = 12;
    localparam int SW  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_rd = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic irq, gather_en, ctx_cache_en;
    logic [7:0] chan_en;
    logic [31:0] ctx_ptr;
    logic [NCH-1:0] ch_done = '0;
    logic [NCH*32-1:0] ch_cmd_ptr;
    logic [NCH-1:0] ch_sema_wr;
    logic [31:0] ch_sema_data;
    logic [NCH*SW-1:0] ch_stat_set = '0;
    logic [NCH*SW-1:0] ch_stat;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb[$];
    logic rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    copro_regfile #(.NCH(NCH), .ADDR_W(AW), .STAT_W(SW)) u0 (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .gather_en(gather_en), .ctx_cache_en(ctx_cache_en),
        .chan_en(chan_en), .ctx_ptr(ctx_ptr), .ch_done(ch_done),
        .ch_cmd_ptr(ch_cmd_ptr), .ch_sema_wr(ch_sema_wr),
        .ch_sema_data(ch_sema_data), .ch_stat_set(ch_stat_set),
        .ch_stat(ch_stat)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pop expected read data once the read has been sampled
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            chk(it.req, bus_rdata, it.exp);
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string req);
        item_t it;
        it.exp = e; it.req = req;
        sb.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 cmd", ch_cmd_ptr[31:0], 32'h0);
        chk("R1 rdata", bus_rdata, 32'h0);
        rd('h000, 32'h0, "R1 ctrl");
        rd('h010, 32'h0, "R1 stat");
        rd('h120, 32'h0, "R1 cstat");

        // R2 control word
        wr('h000, 32'hFFFF_FFFF);
        rd('h000, 32'h00C0_000F, "R2 ctrl readback");
        chk("R2 gather", {30'b0, gather_en, ctx_cache_en}, 32'h3);

        // R3 status is not writable directly
        wr('h010, 32'hF);
        rd('h010, 32'h0, "R3 write ignored");

        // R3 done pulses set pending bits
        ch_done = 4'b0101;
        @(negedge clk);
        ch_done = '0;
        rd('h010, 32'h5, "R3 pending set");
        chk("R5 irq on", {31'b0, irq}, 32'h1);

        // R4 clear by ones
        wr('h018, 32'h1);
        rd('h010, 32'h4, "R4 partial clear");

        // R5 enable gating
        wr('h000, 32'h0);
        chk("R5 irq masked", {31'b0, irq}, 32'h0);
        wr('h000, 32'h4);
        chk("R5 irq bit2", {31'b0, irq}, 32'h1);
        wr('h000, 32'h8);
        chk("R5 irq other enable", {31'b0, irq}, 32'h0);

        // R4 set wins over clear in the same cycle
        ch_done = 4'b0010;
        wr('h018, 32'h2);
        ch_done = '0;
        rd('h010, 32'h6, "R4 set wins");
        wr('h018, 32'hFFFF_FFFF);
        rd('h010, 32'h0, "R4 clear all");

        // R6 channel enable
        wr('h020, 32'h0000_01FF);
        rd('h020, 32'h0000_00FF, "R6 chen readback");
        chk("R6 chan_en", {24'b0, chan_en}, 32'hFF);

        // R7 capability
        rd('h040, 32'h0005_0001, "R7 cap");
        wr('h040, 32'h0);
        rd('h040, 32'h0005_0001, "R7 cap after write");

        // R8 context pointer
        wr('h050, 32'hFFFF_0000);
        rd('h050, 32'hFFFF_0000, "R8 ctx readback");
        chk("R8 ctx_ptr", ctx_ptr, 32'hFFFF_0000);

        // R9 command pointers for every channel
        for (int i = 0; i < NCH; i++)
            wr(AW'('h100 + i * 'h40), 32'h1000_0000 + 32'(i) * 32'h111);
        for (int i = 0; i < NCH; i++) begin
            rd(AW'('h100 + i * 'h40), 32'h1000_0000 + 32'(i) * 32'h111, "R9 cmd readback");
            chk("R9 cmd port", ch_cmd_ptr[i*32 +: 32], 32'h1000_0000 + 32'(i) * 32'h111);
        end

        // R10 semaphore strobe
        chk("R10 idle", {28'b0, ch_sema_wr}, 32'h0);
        wr('h190, 32'h1);
        chk("R10 strobe", {28'b0, ch_sema_wr}, 32'h4);
        chk("R10 data", ch_sema_data, 32'h1);
        @(negedge clk);
        chk("R10 one cycle", {28'b0, ch_sema_wr}, 32'h0);
        rd('h190, 32'h0, "R10 read zero");

        // R11 channel status
        ch_stat_set[3*SW +: SW] = 8'hA5;
        @(negedge clk);
        ch_stat_set = '0;
        rd('h1E0, 32'hA5, "R11 status set");
        chk("R11 port", {24'b0, ch_stat[3*SW +: SW]}, 32'hA5);
        wr('h1E8, 32'h05);
        rd('h1E0, 32'hA0, "R11 partial clear");
        ch_stat_set[3*SW +: SW] = 8'h01;
        wr('h1E8, 32'hFF);
        ch_stat_set = '0;
        rd('h1E0, 32'h01, "R11 set wins");
        wr('h1E8, 32'hFFFF_FFFF);
        rd('h1E0, 32'h0, "R11 wipe");
        rd('h120, 32'h0, "R11 other channel untouched");

        // R12 unmapped accesses
        rd('h030, 32'h0, "R12 unmapped read");
        rd('h204, 32'h0, "R12 beyond windows");
        rd('h102, 32'h0, "R12 unaligned");
        wr('h030, 32'hFFFF_FFFF);
        wr('h200, 32'hDEAD_BEEF);
        wr('h101, 32'hDEAD_BEEF);
        rd('h000, 32'h0000_0008, "R12 ctrl unchanged");
        rd('h100, 32'h1000_0000, "R12 cmd unchanged");
        chk("R12 chan_en unchanged", {24'b0, chan_en}, 32'hFF);

        // R13 read data holds between reads
        rd('h050, 32'hFFFF_0000, "R13 read");
        idle(3);
        chk("R13 hold", bus_rdata, 32'hFFFF_0000);

        idle(2);
        finish_run();
    end
endmodule